// File: doc/BRIEF.md
# Calibrated Seconds Prescaler

This block turns a 32,768 Hz oscillator, presented as a one-cycle clock enable in the system clock domain, into a one-cycle seconds tick. Crystal error is corrected digitally rather than by trimming the oscillator. At the divide-by-256 stage, one second per corrected minute is made shorter, when the clock must run faster, or longer, when it must run slower. Only a programmable number of minutes in a repeating 64-minute cycle receive this correction.

The surrounding calendar logic sends a one-cycle minute strobe each time it rolls a minute. The block keeps its own count of those strobes, modulo 64, to know its position in the correction cycle. The calibration code is sampled only on that strobe, so a new code first acts in the minute that the strobe opens.

A separate uncorrected divider produces a 512 Hz square wave for measuring the crystal. A stop input freezes both dividers in place.

Top module: `calib_prescaler`

## Requirements
- R1: While rst_n is low, sec_tick and ft_out are 0. The minute index resets to 0 and no correction is armed. The first second after reset is nominal.
- R2: With no correction, seconds are 2^LO_BITS × HI_COUNT enabled cycles apart (32,768 by default). sec_tick is high for exactly one clock cycle.
- R3: An edge advances the dividers only when osc_en is 1 and stop is 0. Second lengths are measured in such edges.
- R4: While stop is 1, no sec_tick is produced and ft_out holds its value. When stop clears, the divider continues from its held position, so the next tick arrives within one second.
- R5: cal_code[5] is the sign (1 = faster, 0 = slower) and cal_code[4:0] is the magnitude N. Each minute_pulse increments a 6-bit minute index, wrapping 63 to 0. The minute that the pulse opens is corrected when the new index is below 2N, so at most 62 of 64 minutes are corrected.
- R6: With the sign set to faster, the first second of a corrected minute is shortened by 2^LO_BITS enabled cycles (256).
- R7: With the sign set to slower, the first second of a corrected minute is lengthened by 2^(LO_BITS-1) enabled cycles (128).
- R8: Over any 64 consecutive minutes, the total is the nominal length minus 2N·2^LO_BITS cycles (faster) or plus N·2^LO_BITS cycles (slower). By default this is −512 or +256 cycles per step.
- R9: cal_code is only sampled on minute_pulse. Changing it between pulses does not alter the length of any second.
- R10: A minute_pulse on the same edge as the end of a second arms the correction for the second that begins at that edge.
- R11: ft_out toggles every 2^(LO_BITS-3) enabled cycles (512 Hz from 32,768 Hz), whatever the calibration.
- R12: A magnitude of 0 leaves every second at nominal length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-cycle enable per oscillator period |
| stop | input | 1 | Freezes both dividers while high |
| cal_code | input | CYC_BITS (6) | Bit 5 sign, bits 4:0 magnitude |
| minute_pulse | input | 1 | One-cycle strobe at each minute rollover |
| sec_tick | output | 1 | One-cycle strobe at the end of each second |
| ft_out | output | 1 | Uncorrected 512 Hz test square wave |

## Verification
Two events can land on the same clock edge: the minute strobe that arms a correction, and the wrap that ends a second. The bench runs each sign and magnitude twice. In one run the strobe arrives one cycle after the tick. In the other, the bench predicts the length of the current second and raises the strobe exactly on its final enabled edge. In both runs the first second of every corrected minute must take its corrected length, and the 64-minute total must match the per-step arithmetic.

// File: rtl/calp_pkg.sv
package calp_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Correction pending for the current or next second
    typedef enum logic [1:0] {
        ARM_NONE = 2'd0,
        ARM_FAST = 2'd1,
        ARM_SLOW = 2'd2
    } arm_e;
endpackage

// File: rtl/calp_window.sv
module calp_window
    import calp_pkg::*;
#(
    parameter int CYC_BITS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                minute_pulse,
    input  logic [CYC_BITS-1:0] cal_code,
    input  logic                applied,
    output arm_e                arm
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int MAG_W = CYC_BITS - 1;

    typedef struct packed {
        logic [CYC_BITS-1:0] minute;
        arm_e                arm;
    } win_s;

    win_s                s_d, s_q;
    logic [MAG_W-1:0]    mag;
    logic                sign_fast;
    logic [CYC_BITS-1:0] min_next;
    logic [CYC_BITS-1:0] limit;
    logic                in_win;

    always_comb begin
        mag       = cal_code[MAG_W-1:0];
        sign_fast = cal_code[MAG_W];
        min_next  = s_q.minute + 1'b1;
        limit     = {mag, 1'b0};
        in_win    = min_next < limit;
        s_d       = s_q;
        // A consumed correction disarms; a new boundary decision overrides it
        if (applied) begin
            s_d.arm = ARM_NONE;
        end
        if (minute_pulse) begin
            s_d.minute = min_next;
            s_d.arm    = in_win ? (sign_fast ? ARM_FAST : ARM_SLOW) : ARM_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.minute <= '0;
            s_q.arm    <= ARM_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign arm = s_q.arm;
endmodule

// File: rtl/calp_secdiv.sv
module calp_secdiv
    import calp_pkg::*;
#(
    parameter int LO_BITS  = 8,
    parameter int HI_COUNT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  arm_e arm,
    output logic applied,
    output logic tick
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LO_N   = 1 << LO_BITS;
    localparam int LO_EXT = LO_N + LO_N / 2;
    localparam int LW     = LO_BITS + 1;
    localparam int HW     = $clog2(HI_COUNT);

    typedef struct packed {
        logic [LW-1:0] lo;
        logic [HW-1:0] hi;
        logic          tick;
    } div_s;

    div_s          s_d, s_q;
    logic          last_hi;
    logic          early;
    logic          stretch;
    logic [LW-1:0] lo_lim;
    logic          lo_end;
    logic          sec_end;
    logic          wrap;

    always_comb begin
        last_hi = s_q.hi == HW'(HI_COUNT - 1);
        // Faster: the second ends one low-stage period early
        early   = (arm == ARM_FAST) && (s_q.hi == HW'(HI_COUNT - 2));
        // Slower: the final low-stage period runs half a period longer
        stretch = (arm == ARM_SLOW) && last_hi;
        lo_lim  = stretch ? LW'(LO_EXT - 1) : LW'(LO_N - 1);
        lo_end  = s_q.lo >= lo_lim;
        sec_end = lo_end && (last_hi || early);
        wrap    = step && sec_end;
        applied = wrap && (early || stretch);

        s_d      = s_q;
        s_d.tick = wrap;
        if (step) begin
            if (lo_end) begin
                s_d.lo = '0;
                s_d.hi = sec_end ? '0 : s_q.hi + 1'b1;
            end else begin
                s_d.lo = s_q.lo + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick = s_q.tick;
endmodule

// File: rtl/calp_ftdiv.sv
module calp_ftdiv #(
    parameter int LO_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic ft
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int FT_HALF = (1 << LO_BITS) / 8;
    localparam int FW      = (FT_HALF > 1) ? $clog2(FT_HALF) : 1;

    typedef struct packed {
        logic [FW-1:0] cnt;
        logic          ft;
    } ft_s;

    ft_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (step) begin
            if (s_q.cnt == FW'(FT_HALF - 1)) begin
                s_d.cnt = '0;
                s_d.ft  = ~s_q.ft;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ft = s_q.ft;
endmodule

// File: rtl/calib_prescaler.sv
module calib_prescaler
    import calp_pkg::*;
#(
    parameter int LO_BITS  = 8,
    parameter int HI_COUNT = 128,
    parameter int CYC_BITS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                osc_en,
    input  logic                stop,
    input  logic [CYC_BITS-1:0] cal_code,
    input  logic                minute_pulse,
    output logic                sec_tick,
    output logic                ft_out
);
    timeunit 1ns;
    timeprecision 1ps;

    logic step;
    logic applied;
    arm_e arm;

    assign step = osc_en && !stop;

    calp_window #(
        .CYC_BITS (CYC_BITS)
    ) u_window (
        .clk          (clk),
        .rst_n        (rst_n),
        .minute_pulse (minute_pulse),
        .cal_code     (cal_code),
        .applied      (applied),
        .arm          (arm)
    );

    calp_secdiv #(
        .LO_BITS  (LO_BITS),
        .HI_COUNT (HI_COUNT)
    ) u_secdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .arm     (arm),
        .applied (applied),
        .tick    (sec_tick)
    );

    calp_ftdiv #(
        .LO_BITS (LO_BITS)
    ) u_ftdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .ft    (ft_out)
    );
endmodule

// File: rtl/calib_prescaler_chk.sv
module calib_prescaler_chk #(
    parameter int LO_BITS = 8
) (
    input logic clk,
    input logic rst_n,
    input logic osc_en,
    input logic stop,
    input logic sec_tick,
    input logic ft_out
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int FT_HALF = (1 << LO_BITS) / 8;
    localparam int SW      = $clog2(FT_HALF + 1) + 1;

    logic [SW-1:0] seen_q;
    logic          ft_prev_q;
    logic          step;

    assign step = osc_en && !stop;

    // Enabled edges since the last observed toggle of the test output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q    <= '0;
            ft_prev_q <= 1'b0;
        end else begin
            ft_prev_q <= ft_out;
            if (ft_out != ft_prev_q) begin
                seen_q <= step ? SW'(1) : '0;
            end else if (step) begin
                seen_q <= seen_q + 1'b1;
            end
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> (!sec_tick && $stable(ft_out))); // R3
    AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !sec_tick); // R4
    AST_STOP_FT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> $stable(ft_out)); // R4
    AST_FT_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (ft_out != ft_prev_q) |-> (seen_q == SW'(FT_HALF))); // R11
endmodule

bind calib_prescaler calib_prescaler_chk #(
    .LO_BITS (LO_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_en   (osc_en),
    .stop     (stop),
    .sec_tick (sec_tick),
    .ft_out   (ft_out)
);

// File: tb/calib_prescaler_tb.sv
module calib_prescaler_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LO_BITS  = 4;
    localparam int HI_COUNT = 2;
    localparam int CYC_BITS = 6;
    localparam int LO_N     = 1 << LO_BITS;
    localparam int BASE     = LO_N * HI_COUNT;
    localparam int FT_HALF  = LO_N / 8;
    localparam int SECS     = 130;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                osc_en = 1'b0;
    logic                stop = 1'b0;
    logic                minute_pulse = 1'b0;
    logic [CYC_BITS-1:0] cal_code = '0;
    logic                sec_tick;
    logic                ft_out;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   en_now = 1'b0;
    int   fc = 0;
    logic ft_last = 1'b0;

    always #2.5 clk = ~clk;

    calib_prescaler #(
        .LO_BITS  (LO_BITS),
        .HI_COUNT (HI_COUNT),
        .CYC_BITS (CYC_BITS)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .osc_en       (osc_en),
        .stop         (stop),
        .cal_code     (cal_code),
        .minute_pulse (minute_pulse),
        .sec_tick     (sec_tick),
        .ft_out       (ft_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Expected enabled-edge length of second s (seconds 0,1 form minute 0)
    function automatic int exp_len(input int s, input int mag, input bit fast);
        if (s >= 2 && (s % 2) == 0 && ((s / 2) % 64) < 2 * mag)
            return fast ? BASE - LO_N : BASE + LO_N / 2;
        return BASE;
    endfunction

    // One negedge: account the edge just past and check the test output (R11)
    task automatic edge_step(output bit adv);
        @(negedge clk);
        adv = en_now && !stop;
        if (adv) fc++;
        if (ft_out !== ft_last) begin
            chk(fc == FT_HALF, "R11 test output half period", fc, FT_HALF);
            fc = 0;
            ft_last = ft_out;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; osc_en = 1'b0; en_now = 1'b0; stop = 1'b0; minute_pulse = 1'b0;
        repeat (3) @(negedge clk);
        chk(sec_tick == 1'b0 && ft_out == 1'b0, "R1 reset state", {sec_tick, ft_out}, 0);
        rst_n = 1'b1; fc = 0; ft_last = 1'b0;
    endtask

    task automatic run_cycle(input int mag, input bit fast, input bit coinc,
                             input bit scr, input bit gap);
        int total = 0;
        bit adv;
        string tag;
        logic [CYC_BITS-1:0] good;
        good = {fast, mag[CYC_BITS-2:0]};
        do_reset();
        cal_code = good; en_now = 1'b1; osc_en = 1'b1;
        for (int s = 0; s < SECS; s++) begin
            int want = exp_len(s, mag, fast);
            int c = 0;
            bit done = 1'b0;
            while (!done) begin
                edge_step(adv);
                if (adv) c++;
                if (minute_pulse) begin
                    minute_pulse = 1'b0;
                    if (scr) cal_code = ~good;
                end
                if (sec_tick) done = 1'b1;
                else if (c > 4 * BASE) begin
                    chk(1'b0, "R2 seconds tick missing", c, want);
                    done = 1'b1;
                end else if (coinc && (s % 2) == 1 && c == want - 1 && s < SECS - 1) begin
                    cal_code = good;
                    minute_pulse = 1'b1;
                end
                if (gap) begin
                    en_now = ~en_now;
                    osc_en = en_now;
                end
            end
            if (s == 0) tag = "R1 first second";
            else if (mag == 0) tag = "R12 zero magnitude";
            else if (want != BASE) tag = fast ? "R6 shortened second" : "R7 lengthened second";
            else if (coinc) tag = "R10 coincident boundary";
            else if (scr) tag = "R9 code between boundaries";
            else if (gap) tag = "R3 gated enable";
            else tag = "R2 nominal second";
            if (coinc && want != BASE) tag = {tag, " R10"};
            if (scr) tag = {tag, " R9"};
            if (gap) tag = {tag, " R3"};
            chk(c == want, $sformatf("%s (mag %0d sec %0d)", tag, mag, s), c, want);
            if (s >= 2) total += c;
            if (!coinc && (s % 2) == 1 && s < SECS - 1) begin
                cal_code = good;
                minute_pulse = 1'b1;
            end
        end
        begin
            int exp_tot = 128 * BASE + (fast ? -2 * mag * LO_N : mag * LO_N);
            chk(total == exp_tot, $sformatf("R8 cycle total R5 (mag %0d fast %0d)", mag, fast),
                total, exp_tot);
        end
    endtask

    task automatic stop_test();
        bit adv;
        int c = 0;
        bit quiet = 1'b1;
        logic ft_hold;
        do_reset();
        cal_code = '0; en_now = 1'b1; osc_en = 1'b1;
        while (c < 10) begin
            edge_step(adv);
            if (adv) c++;
            if (sec_tick) quiet = 1'b0;
        end
        stop = 1'b1;
        ft_hold = ft_out;
        for (int k = 0; k < 40; k++) begin
            edge_step(adv);
            if (sec_tick || ft_out !== ft_hold) quiet = 1'b0;
        end
        chk(quiet, "R4 held while stopped", 0, 1);
        stop = 1'b0;
        while (!sec_tick && c < 4 * BASE) begin
            edge_step(adv);
            if (adv) c++;
        end
        chk(c == BASE, "R4 resume from held position", c, BASE);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        stop_test();
        run_cycle(0,  1'b1, 1'b0, 1'b0, 1'b0);
        run_cycle(1,  1'b1, 1'b0, 1'b0, 1'b0);
        run_cycle(1,  1'b0, 1'b0, 1'b0, 1'b0);
        run_cycle(6,  1'b1, 1'b0, 1'b0, 1'b0);
        run_cycle(6,  1'b0, 1'b0, 1'b1, 1'b0);
        run_cycle(15, 1'b1, 1'b1, 1'b0, 1'b0);
        run_cycle(15, 1'b0, 1'b1, 1'b0, 1'b0);
        run_cycle(31, 1'b1, 1'b0, 1'b0, 1'b0);
        run_cycle(31, 1'b0, 1'b1, 1'b0, 1'b0);
        run_cycle(3,  1'b1, 1'b0, 1'b0, 1'b1);
        run_cycle(20, 1'b0, 1'b0, 1'b1, 1'b1);
        summary();
        $finish;
    end
endmodule